// File: doc/BRIEF.md
# Embedded-Clock Framing Serializer

This block turns a 10-bit parallel word (eight payload bits and two control bits) into a 12-bit serial frame. Each frame opens with a high framing bit and closes with a low framing bit. That fixed high-then-low pair is a clock edge built into the stream, so a receiver can recover timing whatever the payload holds. The block runs on a bit clock at twelve times the word rate. It samples the transmit word clock as a level and captures the parallel word on the word-clock edge that a select input chooses. A captured word waits in a holding register until the next frame boundary. The block then sends that word in every frame until a newer word replaces it.

Two sync request inputs replace the data with a lock pattern for whole frames. An enable input and a power-down input take the serial line off the bus. Power-down also resets the framing, and sending restarts on the first bit-clock edge after it is released.

Top module: `embclk_serializer`

## Requirements
- R1: A frame lasts 12 bit-clock cycles and sends one bit per cycle: position 0 is a 1 (start), positions 1 to 10 carry word bits 0 to 9 least significant first, and position 11 is a 0 (stop). The first frame is loaded on the first bit-clock edge after reset is released.
- R2: While reset is held, ser_out is 0 and ser_oe follows the enable and power-down inputs.
- R3: With edge_sel = 1 the word is captured on a rising edge of clk_word, and with edge_sel = 0 on a falling edge. The other edge does not capture, and the frame keeps the earlier word.
- R4: A word captured during a frame does not change that frame. It is sent in full in the next frame.
- R5: If sync_a or sync_b is high at a frame boundary, that frame is the lock pattern: positions 0 to 5 are 1 and positions 6 to 11 are 0.
- R6: Changing a sync request in the middle of a frame does not alter the frame in progress. Once the request is dropped, the next frame carries data again.
- R7: When no new word has been captured, the last captured word is sent again in every frame.
- R8: While data_en is 0, ser_oe and ser_out are 0. Framing keeps running, so frame boundaries do not move.
- R9: While pwr_dn is 1, ser_oe and ser_out are 0 and framing is held. On the first bit-clock edge after pwr_dn falls, a new frame is loaded.
- R10: Every frame, data or sync, ends with a 0 in position 11 and starts with a 1 in position 0, so each frame has at least one transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, 12 times the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_word | input | 1 | Transmit word clock, sampled as a level |
| edge_sel | input | 1 | 1 captures on a rising clk_word edge, 0 on a falling one |
| word_in | input | 10 | Parallel word: 8 payload bits and 2 control bits |
| sync_a | input | 1 | Lock-pattern request |
| sync_b | input | 1 | Second lock-pattern request |
| data_en | input | 1 | Drives the serial line when high |
| pwr_dn | input | 1 | Power-down: line off, framing held |
| ser_out | output | 1 | Serial data, 0 when not driven |
| ser_oe | output | 1 | Output enable for the line driver |

## Verification
The assertions check every cycle that the stop bit is low at each boundary and that a loaded data frame starts high. They also check that a sync request at a boundary loads the lock pattern, that mid-frame cycles only shift and count, and that power-down holds the framing in its restart state. The bench's scenarios cover the rest: the exact bit order of data words under both capture edges, that the unselected edge is ignored, the delay of a word captured mid-frame, frame alignment through enable and power-down, and the restart point afterwards.

// File: rtl/embclk_serializer.sv
module embclk_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              clk_word,
  input  logic              edge_sel,
  input  logic [WORD_W-1:0] word_in,
  input  logic              sync_a,
  input  logic              sync_b,
  input  logic              data_en,
  input  logic              pwr_dn,
  output logic              ser_out,
  output logic              ser_oe
);
  localparam int FRAME_W   = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int LAST      = FRAME_W - 1;
  localparam int SYNC_ONES = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_PAT =
    {{(FRAME_W-SYNC_ONES){1'b0}}, {SYNC_ONES{1'b1}}};

  logic              cw_q;
  logic [WORD_W-1:0] hold;
  logic [CNT_W-1:0]  cnt;
  logic [FRAME_W-1:0] shreg;

  wire cap      = edge_sel ? (clk_word & ~cw_q) : (~clk_word & cw_q);
  wire sync_req = sync_a | sync_b;
  wire at_end   = (cnt == CNT_W'(LAST));
  wire [FRAME_W-1:0] data_frame = {1'b0, hold, 1'b1};

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      cw_q <= 1'b0;
      hold <= '0;
    end else begin
      cw_q <= clk_word;
      if (cap) hold <= word_in;
    end
  end

  always_ff @(posedge clk_bit) begin
    if (!rst_n || pwr_dn) begin
      cnt   <= CNT_W'(LAST);
      shreg <= '0;
    end else if (at_end) begin
      cnt   <= '0;
      shreg <= sync_req ? SYNC_PAT : data_frame;
    end else begin
      cnt   <= cnt + 1'b1;
      shreg <= shreg >> 1;
    end
  end

  assign ser_oe  = data_en & ~pwr_dn;
  assign ser_out = ser_oe & shreg[0];
endmodule

// File: rtl/embclk_serializer_chk.sv
module embclk_serializer_chk #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_dn,
  input logic               sync_a,
  input logic               sync_b,
  input logic [CNT_W-1:0]   cnt,
  input logic [FRAME_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] LASTC = CNT_W'(FRAME_W - 1);
  localparam int ONES = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] PAT = {{(FRAME_W-ONES){1'b0}}, {ONES{1'b1}}};

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LASTC) |-> (shreg[0] == 1'b0)); // R10
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && cnt == LASTC && !(sync_a || sync_b)) |=> (shreg[0] == 1'b1)); // R1
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && cnt == LASTC && (sync_a || sync_b)) |=> (shreg == PAT)); // R5
  AST_MID_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && cnt != LASTC) |=>
      (shreg == ($past(shreg) >> 1)) && (cnt == CNT_W'($past(cnt) + 1'b1))); // R4
  AST_PWRDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (cnt == LASTC && shreg == '0)); // R9
endmodule

bind embclk_serializer embclk_serializer_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk_bit), .rst_n(rst_n), .pwr_dn(pwr_dn), .sync_a(sync_a),
  .sync_b(sync_b), .cnt(cnt), .shreg(shreg)
);

// File: tb/embclk_serializer_tb.sv
module embclk_serializer_tb;
  localparam int FW = 12;
  localparam logic [FW-1:0] SYNC_EXP = 12'h03F;
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 10'h3FF}, {1'b0, 10'h000}, {1'b1, 10'h155}, {1'b0, 10'h2AA},
    {1'b1, 10'h001}, {1'b0, 10'h200}, {1'b1, 10'h0F0}, {1'b0, 10'h30C}
  };

  logic clk = 0, rst_n = 0, clk_word = 0, edge_sel = 1;
  logic [9:0] word_in = '0;
  logic sync_a = 0, sync_b = 0, data_en = 1, pwr_dn = 0;
  logic ser_out, ser_oe;
  int total = 0, bad = 0, ecnt = 0;
  bit done = 0;

  embclk_serializer u_dut (
    .clk_bit(clk), .rst_n(rst_n), .clk_word(clk_word), .edge_sel(edge_sel),
    .word_in(word_in), .sync_a(sync_a), .sync_b(sync_b), .data_en(data_en),
    .pwr_dn(pwr_dn), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk)
    if (!rst_n || pwr_dn) ecnt <= 0; else ecnt <= ecnt + 1;

  function automatic logic [FW-1:0] frm(input logic [9:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get_frame(output logic [FW-1:0] f, output int waited,
                           input int act_at, input int act_kind, input logic [9:0] aux);
    waited = 0;
    @(posedge clk);
    @(negedge clk);
    while (ecnt % FW != 1) begin waited++; @(negedge clk); end
    for (int i = 0; i < FW; i++) begin
      if (i > 0) @(negedge clk);
      f[i] = ser_out;
      if (i == act_at) begin
        if (act_kind == 1) begin word_in = aux; clk_word = 1'b1; end
        if (act_kind == 2) sync_a = 1'b0;
      end
    end
  endtask

  task automatic make_edge(input logic sel, input logic [9:0] w);
    @(negedge clk);
    edge_sel = sel;
    clk_word = sel ? 1'b0 : 1'b1;
    @(negedge clk);
    word_in  = w;
    clk_word = sel ? 1'b1 : 1'b0;
    @(posedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #4ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f;
    logic [FW-1:0] z;
    int w;
    repeat (3) @(negedge clk);
    chk("R2 reset {oe,out}", {10'b0, ser_oe, ser_out}, 12'b10);
    rst_n = 1;

    for (int k = 0; k < 8; k++) begin
      make_edge(VEC[k][10], VEC[k][9:0]);
      get_frame(f, w, -1, 0, '0);
      chk($sformatf("R1 R3 vector %0d", k), f, frm(VEC[k][9:0]));
    end

    get_frame(f, w, -1, 0, '0);
    chk("R7 repeat last word", f, frm(10'h30C));

    @(negedge clk); edge_sel = 1;
    @(negedge clk); word_in = 10'h3C3; clk_word = 1;
    @(negedge clk); word_in = 10'h155; clk_word = 0;
    get_frame(f, w, -1, 0, '0);
    chk("R3 unselected edge ignored", f, frm(10'h3C3));

    get_frame(f, w, 4, 1, 10'h0A5);
    chk("R4 frame in progress kept", f, frm(10'h3C3));
    get_frame(f, w, -1, 0, '0);
    chk("R4 captured word next frame", f, frm(10'h0A5));

    @(negedge clk); sync_a = 1;
    get_frame(f, w, -1, 0, '0);
    chk("R5 sync_a pattern", f, SYNC_EXP);
    get_frame(f, w, 3, 2, '0);
    chk("R6 sync drop mid-frame", f, SYNC_EXP);
    get_frame(f, w, -1, 0, '0);
    chk("R6 data after sync", f, frm(10'h0A5));

    sync_b = 1;
    get_frame(f, w, -1, 0, '0);
    sync_b = 0;
    chk("R5 sync_b pattern", f, SYNC_EXP);
    get_frame(f, w, -1, 0, '0);
    chk("R10 data frame edges", {10'b0, f[11], f[0]}, 12'b01);

    @(negedge clk); data_en = 0;
    z = '0;
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      z[i] = ser_oe | ser_out;
    end
    chk("R8 line off while disabled", z, '0);
    data_en = 1;
    get_frame(f, w, -1, 0, '0);
    chk("R8 alignment kept", f, frm(10'h0A5));

    @(negedge clk); pwr_dn = 1;
    z = '0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      z[i] = ser_oe | ser_out;
    end
    chk("R9 line off in power-down", z, '0);
    pwr_dn = 0;
    get_frame(f, w, -1, 0, '0);
    chk("R9 restart frame", f, frm(10'h0A5));
    chk("R9 restart on first edge", 12'(w), 12'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule